// File: doc/BRIEF.md
# Privileged Status/Cause Interrupt Gate

This block keeps the processor's privileged Status and Cause registers and turns their contents into a single interrupt-request level for the pipeline. Software writes either register through its own write port. Each write carries a bit mask, and the block narrows that mask further according to the architecture release the core is configured for. Hardware interrupt lines are captured into the upper pending bits of Cause on every clock. The two software interrupt bits are set and cleared only by Cause writes.

The block has two detection modes. In the default mode an interrupt is requested when any pending bit meets an enabled mask bit. When an external interrupt controller is attached, the eight pending bits are read as one priority number, and the request fires only if that number is strictly greater than the mask field read the same way. The block also reports when the counter-disable bit in Cause changes level. When a software interrupt bit changes, it gives a one-cycle strobe together with the new level, so neighbouring logic can follow.

Top module: `prv_intr_ctl`

## Requirements
- R1: After reset, Status reads 0x00000004 (error-level bit 2 set), Cause reads 0, and irqReq, countStop, swIrqStb and swIrqLvl are all 0.
- R2: A Status write replaces exactly the bits set in stWrMask and keeps every other bit. The new value is visible on statusOut after the clock edge that samples stWrEn. With stWrEn low, Status holds its value.
- R3: A Cause write changes only those caWrMask bits that are architecturally writable. These are the software bits 9:8, bit 22 (watch pending) and bit 23 (vector select). Bit 27 (counter disable) is added to this set when rel2 is high.
- R4: Cause bits 15:10 take the value of hwPend[5:0] on every clock edge, with one cycle of delay. A Cause write has no effect on these bits.
- R5: irqReq is 0 whenever any of these holds: Status bit 0 (enable) is 0, Status bit 1 (exception level) is 1, Status bit 2 (error level) is 1, tcExempt is 1, or dbgMode is 1.
- R6: When eicMode is low and nothing blocks, irqReq is 1 exactly when Cause[15:8] AND Status[15:8] is nonzero. irqReq is registered from the stored registers, so it reflects a register change one clock after that register updates.
- R7: When eicMode is high and nothing blocks, irqReq is 1 exactly when Cause[15:8], read as an unsigned number, is strictly greater than Status[15:8]. An equal value gives 0.
- R8: With rel6 high, a Cause write may clear bit 22 but cannot set it.
- R9: With rel6 high, a Status write may clear bits 20 and 19 but cannot set them.
- R10: With rel6 high, a Status write whose mask covers both bits 4:3 and whose data puts 3 into bits 4:3 leaves bits 4:3 unchanged. The other bits of that write still apply. When the mask does not cover both bits, the value 3 is not filtered.
- R11: countStop equals Cause bit 27, so it rises when that bit is set and falls when it is cleared.
- R12: swIrqStb[i] pulses high for one cycle in the same cycle that Cause bit 8+i shows a changed value. During that pulse swIrqLvl[i] carries the new value of the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stWrEn | input | 1 | Status write enable |
| stWrData | input | 32 | Status write data |
| stWrMask | input | 32 | Implemented writable bits of Status for this write |
| caWrEn | input | 1 | Cause write enable |
| caWrData | input | 32 | Cause write data |
| caWrMask | input | 32 | Bits of Cause this write intends to change |
| hwPend | input | 6 | Hardware interrupt lines, captured into Cause[15:10] |
| dbgMode | input | 1 | Core is in debug mode; blocks interrupts |
| tcExempt | input | 1 | Current thread is exempt from interrupts |
| eicMode | input | 1 | Priority comparison mode for an external controller |
| rel2 | input | 1 | Release-2 behaviour: counter-disable bit writable |
| rel6 | input | 1 | Release-6 write restrictions active |
| statusOut | output | 32 | Current Status register |
| causeOut | output | 32 | Current Cause register |
| irqReq | output | 1 | Registered interrupt request |
| countStop | output | 1 | Counter-disable level |
| swIrqStb | output | 2 | One-cycle change strobes for the software interrupt bits |
| swIrqLvl | output | 2 | Current levels of the software interrupt bits |

## Verification
A wrongly narrowed write mask is visible on statusOut or causeOut one clock after the offending write, so each write test reads the register straight back. Detection faults, such as a wrong blocking term, AND used where a comparison belongs, or an off-by-one in the compare, first appear on irqReq one clock after the registers settle. The tests therefore step pending and mask values across the equal boundary in both modes. A lost or late strobe can only be seen in the single cycle after a Cause write, which is why the strobe is sampled in that cycle and again one cycle later.

// File: rtl/prv_intr_pkg.sv
package prv_intr_pkg;
  localparam int REG_W = 32;
  localparam int IP_LO = 8;
  localparam int IE_BIT = 0;
  localparam int EXL_BIT = 1;
  localparam int ERL_BIT = 2;
  localparam int KSU_LO = 3;
  localparam int KSU_HI = 4;
  localparam int NMI_BIT = 19;
  localparam int SR_BIT = 20;
  localparam int WP_BIT = 22;
  localparam int IV_BIT = 23;
  localparam int DC_BIT = 27;
  localparam logic [REG_W-1:0] STATUS_RST = 32'h0000_0004;

  typedef struct packed {
    logic             stEn;
    logic [REG_W-1:0] stMask;
    logic             caEn;
    logic [REG_W-1:0] caMask;
  } wrCtl_t;
endpackage

// File: rtl/prv_intr_wrctl.sv
module prv_intr_wrctl
  import prv_intr_pkg::*;
#(
  parameter int SW_W = 2
) (
  input  logic             stWrEn,
  input  logic [REG_W-1:0] stWrData,
  input  logic [REG_W-1:0] stWrMask,
  input  logic             caWrEn,
  input  logic [REG_W-1:0] caWrData,
  input  logic [REG_W-1:0] caWrMask,
  input  logic             rel2,
  input  logic             rel6,
  output wrCtl_t           ctl
);
  localparam logic [REG_W-1:0] SW_MASK = ((REG_W'(1) << SW_W) - REG_W'(1)) << IP_LO;
  localparam logic [REG_W-1:0] CA_BASE = SW_MASK | (REG_W'(1) << WP_BIT) | (REG_W'(1) << IV_BIT);

  logic [REG_W-1:0] sMask;
  logic [REG_W-1:0] cMask;

  // Status: release-6 filters for the one-way bits and the supervisor-mode code
  always_comb begin
    sMask = stWrMask;
    if (rel6) begin
      if ((&stWrMask[KSU_HI:KSU_LO]) && (&stWrData[KSU_HI:KSU_LO]))
        sMask[KSU_HI:KSU_LO] = '0;
      sMask[SR_BIT]  = stWrMask[SR_BIT]  & ~stWrData[SR_BIT];
      sMask[NMI_BIT] = stWrMask[NMI_BIT] & ~stWrData[NMI_BIT];
    end
  end

  // Cause: fixed writable set, counter-disable from release 2, watch bit clear-only on release 6
  always_comb begin
    cMask = CA_BASE;
    if (rel2) cMask[DC_BIT] = 1'b1;
    if (rel6) cMask[WP_BIT] = ~caWrData[WP_BIT];
    cMask = cMask & caWrMask;
  end

  assign ctl = '{stEn: stWrEn, stMask: sMask, caEn: caWrEn, caMask: cMask};

  always_comb begin
    if (rel6 && ctl.caEn && caWrData[WP_BIT])
      assert_wp_clear_only_R8: assert (!ctl.caMask[WP_BIT]);
    if (rel6 && ctl.stEn && (stWrData[SR_BIT] || stWrData[NMI_BIT]))
      assert_sr_nmi_clear_only_R9: assert (!(ctl.stMask[SR_BIT] && stWrData[SR_BIT])
                                         && !(ctl.stMask[NMI_BIT] && stWrData[NMI_BIT]));
  end
endmodule

// File: rtl/prv_intr_regs.sv
module prv_intr_regs
  import prv_intr_pkg::*;
#(
  parameter int HW_W = 6,
  parameter int SW_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrCtl_t           ctl,
  input  logic [REG_W-1:0] stWrData,
  input  logic [REG_W-1:0] caWrData,
  input  logic [HW_W-1:0]  hwPend,
  input  logic             dbgMode,
  input  logic             tcExempt,
  input  logic             eicMode,
  output logic [REG_W-1:0] statusOut,
  output logic [REG_W-1:0] causeOut,
  output logic             irqReq,
  output logic             countStop,
  output logic [SW_W-1:0]  swIrqStb,
  output logic [SW_W-1:0]  swIrqLvl
);
  localparam int IP_W  = HW_W + SW_W;
  localparam int IP_HI = IP_LO + IP_W - 1;
  localparam int HW_LO = IP_LO + SW_W;

  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] causeQ;
  logic [REG_W-1:0] causeNext;
  logic [SW_W-1:0]  swStbQ;
  logic             irqQ;
  logic             blocked;
  logic [IP_W-1:0]  pendF;
  logic [IP_W-1:0]  maskF;
  logic             hit;

  always_comb begin
    causeNext = causeQ;
    if (ctl.caEn) causeNext = (causeQ & ~ctl.caMask) | (caWrData & ctl.caMask);
    causeNext[IP_HI:HW_LO] = hwPend;
  end

  always_comb begin
    blocked = !statusQ[IE_BIT] || statusQ[EXL_BIT] || statusQ[ERL_BIT] || tcExempt || dbgMode;
    pendF = causeQ[IP_HI:IP_LO];
    maskF = statusQ[IP_HI:IP_LO];
    hit = eicMode ? (pendF > maskF) : (|(pendF & maskF));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= STATUS_RST;
      causeQ  <= '0;
      swStbQ  <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (ctl.stEn) statusQ <= (statusQ & ~ctl.stMask) | (stWrData & ctl.stMask);
      causeQ <= causeNext;
      swStbQ <= causeNext[IP_LO +: SW_W] ^ causeQ[IP_LO +: SW_W];
      irqQ   <= hit && !blocked;
    end
  end

  assign statusOut = statusQ;
  assign causeOut  = causeQ;
  assign irqReq    = irqQ;
  assign countStop = causeQ[DC_BIT];
  assign swIrqStb  = swStbQ;
  assign swIrqLvl  = causeQ[IP_LO +: SW_W];

  assert_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(!statusQ[IE_BIT] || statusQ[EXL_BIT] || statusQ[ERL_BIT] || tcExempt || dbgMode) |-> !irqQ);

  assert_hw_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> causeQ[IP_HI:HW_LO] == $past(hwPend));

  assert_status_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(ctl.stEn)) |-> $stable(statusQ));

  for (genvar i = 0; i < SW_W; i++) begin : g_swChk
    assert_sw_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && (causeQ[IP_LO+i] != $past(causeQ[IP_LO+i]))) |-> swStbQ[i]);
  end
endmodule

// File: rtl/prv_intr_ctl.sv
module prv_intr_ctl
  import prv_intr_pkg::*;
#(
  parameter int HW_W = 6,
  parameter int SW_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stWrEn,
  input  logic [REG_W-1:0] stWrData,
  input  logic [REG_W-1:0] stWrMask,
  input  logic             caWrEn,
  input  logic [REG_W-1:0] caWrData,
  input  logic [REG_W-1:0] caWrMask,
  input  logic [HW_W-1:0]  hwPend,
  input  logic             dbgMode,
  input  logic             tcExempt,
  input  logic             eicMode,
  input  logic             rel2,
  input  logic             rel6,
  output logic [REG_W-1:0] statusOut,
  output logic [REG_W-1:0] causeOut,
  output logic             irqReq,
  output logic             countStop,
  output logic [SW_W-1:0]  swIrqStb,
  output logic [SW_W-1:0]  swIrqLvl
);
  wrCtl_t ctl;

  prv_intr_wrctl #(.SW_W(SW_W)) wrctl_i (
    .stWrEn(stWrEn), .stWrData(stWrData), .stWrMask(stWrMask),
    .caWrEn(caWrEn), .caWrData(caWrData), .caWrMask(caWrMask),
    .rel2(rel2), .rel6(rel6), .ctl(ctl)
  );

  prv_intr_regs #(.HW_W(HW_W), .SW_W(SW_W)) regs_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .stWrData(stWrData), .caWrData(caWrData), .hwPend(hwPend),
    .dbgMode(dbgMode), .tcExempt(tcExempt), .eicMode(eicMode),
    .statusOut(statusOut), .causeOut(causeOut), .irqReq(irqReq),
    .countStop(countStop), .swIrqStb(swIrqStb), .swIrqLvl(swIrqLvl)
  );
endmodule

// File: tb/prv_intr_ctl_tb_top.sv
`timescale 1ns/1ps
module prv_intr_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stWrEn = 1'b0, caWrEn = 1'b0;
  logic [31:0] stWrData = '0, stWrMask = '0, caWrData = '0, caWrMask = '0;
  logic [5:0]  hwPend = '0;
  logic        dbgMode = 1'b0, tcExempt = 1'b0, eicMode = 1'b0, rel2 = 1'b0, rel6 = 1'b0;
  logic [31:0] statusOut, causeOut;
  logic        irqReq, countStop;
  logic [1:0]  swIrqStb, swIrqLvl;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  prv_intr_ctl dut_i (
    .clk(clk), .rstN(rstN), .stWrEn(stWrEn), .stWrData(stWrData), .stWrMask(stWrMask),
    .caWrEn(caWrEn), .caWrData(caWrData), .caWrMask(caWrMask), .hwPend(hwPend),
    .dbgMode(dbgMode), .tcExempt(tcExempt), .eicMode(eicMode), .rel2(rel2), .rel6(rel6),
    .statusOut(statusOut), .causeOut(causeOut), .irqReq(irqReq), .countStop(countStop),
    .swIrqStb(swIrqStb), .swIrqLvl(swIrqLvl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic settle(); tick(); tick(); endtask

  task automatic wrSt(input logic [31:0] d, input logic [31:0] m);
    @(negedge clk); stWrData = d; stWrMask = m; stWrEn = 1'b1;
    @(negedge clk); stWrEn = 1'b0;
  endtask

  task automatic wrCa(input logic [31:0] d, input logic [31:0] m);
    @(negedge clk); caWrData = d; caWrMask = m; caWrEn = 1'b1;
    @(negedge clk); caWrEn = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 status", statusOut, 32'h4);
    chk("R1 cause", causeOut, 32'h0);
    chk("R1 irq/stop/stb/lvl", {26'd0, irqReq, countStop, swIrqStb, swIrqLvl}, 32'h0);
  endtask

  task automatic testStatusWrite();
    wrSt(32'hFFFF_FFFF, 32'h0000_FF01);
    chk("R2 masked write", statusOut, 32'h0000_FF05);
    wrSt(32'h0000_FF01, 32'hFFFF_FFFF);
    chk("R2 full write", statusOut, 32'h0000_FF01);
    @(negedge clk); stWrData = 32'hDEAD_BEEF; stWrMask = '1;
    tick();
    chk("R2 hold without enable", statusOut, 32'h0000_FF01);
  endtask

  task automatic testNormal();
    wrSt(32'h0000_0401, '1);
    @(negedge clk); hwPend = 6'b000001;
    @(negedge clk);
    chk("R4 hw pending captured", causeOut, 32'h0000_0400);
    chk("R6 irq latency one cycle", {31'd0, irqReq}, 32'd0);
    tick();
    chk("R6 AND hit", {31'd0, irqReq}, 32'd1);
    @(negedge clk); hwPend = 6'b000010;
    settle();
    chk("R6 AND miss", {31'd0, irqReq}, 32'd0);
    wrCa(32'h0000_FC00, '1);
    chk("R4 write to hw bits ignored", causeOut, 32'h0000_0800);
  endtask

  task automatic testBlock();
    wrSt(32'h0000_0801, '1); tick();
    chk("R6 enabled line", {31'd0, irqReq}, 32'd1);
    @(negedge clk); dbgMode = 1'b1; settle();
    chk("R5 debug blocks", {31'd0, irqReq}, 32'd0);
    @(negedge clk); dbgMode = 1'b0; tcExempt = 1'b1; settle();
    chk("R5 exempt blocks", {31'd0, irqReq}, 32'd0);
    @(negedge clk); tcExempt = 1'b0;
    wrSt(32'h0000_0803, '1); tick();
    chk("R5 EXL blocks", {31'd0, irqReq}, 32'd0);
    wrSt(32'h0000_0805, '1); tick();
    chk("R5 ERL blocks", {31'd0, irqReq}, 32'd0);
    wrSt(32'h0000_0800, '1); tick();
    chk("R5 IE clear blocks", {31'd0, irqReq}, 32'd0);
    wrSt(32'h0000_0801, '1); tick();
    chk("R5 unblocked again", {31'd0, irqReq}, 32'd1);
  endtask

  task automatic testEic();
    @(negedge clk); eicMode = 1'b1;
    wrSt(32'h0000_0501, '1); tick();
    chk("R7 pend 8 > mask 5", {31'd0, irqReq}, 32'd1);
    wrSt(32'h0000_0801, '1); tick();
    chk("R7 equal gives none", {31'd0, irqReq}, 32'd0);
    wrSt(32'h0000_0901, '1); tick();
    chk("R7 pend below mask", {31'd0, irqReq}, 32'd0);
    @(negedge clk); eicMode = 1'b0;
    wrSt(32'h0000_0501, '1); tick();
    chk("R6 no common bit in normal mode", {31'd0, irqReq}, 32'd0);
    @(negedge clk); hwPend = '0; settle();
  endtask

  task automatic testCause();
    @(negedge clk); caWrData = '1; caWrMask = '1; caWrEn = 1'b1;
    @(negedge clk); caWrEn = 1'b0;
    chk("R3 writable set, no rel2", causeOut, 32'h00C0_0300);
    chk("R12 strobes and levels", {28'd0, swIrqStb, swIrqLvl}, 32'hF);
    chk("R11 counter running", {31'd0, countStop}, 32'd0);
    tick();
    chk("R12 strobe one cycle", {30'd0, swIrqStb}, 32'd0);
    wrCa(32'h0, 32'h0000_0100);
    chk("R3 partial mask", causeOut, 32'h00C0_0200);
    chk("R12 single line", {28'd0, swIrqStb, swIrqLvl}, 32'h6);
    @(negedge clk); rel2 = 1'b1;
    wrCa(32'h0800_0000, 32'h0800_0000);
    chk("R11 counter stopped", {31'd0, countStop}, 32'd1);
    chk("R3 DC with rel2", causeOut, 32'h08C0_0200);
    wrCa(32'h0, '1);
    chk("R11 counter restarted", {31'd0, countStop}, 32'd0);
    chk("R12 falling line strobe", {28'd0, swIrqStb, swIrqLvl}, 32'h8);
    wrSt(32'h0000_0101, '1);
    wrCa(32'h0000_0100, '1); tick();
    chk("R6 software line raises irq", {31'd0, irqReq}, 32'd1);
    wrCa(32'h0, '1);
  endtask

  task automatic testWp();
    @(negedge clk); rel6 = 1'b1;
    wrCa(32'h0040_0000, '1);
    chk("R8 set blocked", causeOut, 32'h0);
    @(negedge clk); rel6 = 1'b0;
    wrCa(32'h0040_0000, '1);
    chk("R8 set allowed pre-rel6", causeOut, 32'h0040_0000);
    @(negedge clk); rel6 = 1'b1;
    wrCa(32'h0, '1);
    chk("R8 clear allowed", causeOut, 32'h0);
  endtask

  task automatic testSr();
    @(negedge clk); rel6 = 1'b0;
    wrSt(32'h0018_0004, '1);
    chk("R9 set pre-rel6", statusOut, 32'h0018_0004);
    @(negedge clk); rel6 = 1'b1;
    wrSt(32'h0010_0004, '1);
    chk("R9 NMI cleared", statusOut, 32'h0010_0004);
    wrSt(32'h0, '1);
    chk("R9 SR cleared", statusOut, 32'h0);
    wrSt(32'h0018_0000, '1);
    chk("R9 set blocked", statusOut, 32'h0);
  endtask

  task automatic testKsu();
    wrSt(32'h19, '1);
    chk("R10 KSU=3 ignored, IE written", statusOut, 32'h01);
    wrSt(32'h10, '1);
    chk("R10 KSU=2 accepted", statusOut, 32'h10);
    wrSt(32'h18, 32'hFFFF_FFEF);
    chk("R10 no supervisor, not filtered", statusOut, 32'h18);
    @(negedge clk); rel6 = 1'b0;
    wrSt(32'h19, '1);
    chk("R10 pre-rel6 accepted", statusOut, 32'h19);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testStatusWrite();
    testNormal();
    testBlock();
    testEic();
    testCause();
    testWp();
    testSr();
    testKsu();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule